// File: doc/BRIEF.md
# Atomic Swap Memory Access Unit

This block is a memory target shared by several requesters. It holds a small byte-addressed store built from 64-bit words. It serves reads, byte-enabled writes, unconditional swaps, compare-gated swaps and invalidates. A swap of either kind reads the old contents and writes the new ones in the same clock edge, so no other access can come between the read and the write. The old contents always go back to the requester.

Writes are gated by an external reservation monitor. A read marked as linked raises a reservation pulse that carries its address and requester. Every write request is then committed or dropped by the monitor's `wr_allow` answer in the same cycle. A pulse on every memory update lets the monitor clear reservations that the update has broken. An inhibit input turns a request into a no-op. For each requester the block also keeps saturating counters of its activity, which are read through a select port.

Top module: `atomic_mem_unit`

## Requirements
- R1: Command code 0 (read) returns the addressed bytes in their lanes of the 64-bit little-endian data word, with all other lanes zero. Size codes 0..3 mean 1, 2, 4 and 8 bytes, and the response comes one clock after the request.
- R2: Command code 1 (write) updates only the enabled byte lanes, and only when `wr_allow` is 1 in the request cycle. A rejected write leaves memory unchanged and answers with `rsp_ok`=0.
- R3: Command code 2 (swap) returns the old bytes and stores the new bytes in the same clock edge.
- R4: Command code 3 (compare swap) stores only when the enabled bytes equal the same lanes of `req_cmp`. It returns the old bytes either way, and `rsp_ok` shows whether the store happened.
- R5: `rsp_err`=1 with no memory change is reported for a compare swap of size code 0 or 1, for an address not aligned to its size, and for command codes 5..7.
- R6: A linked read pulses `resv_set` in its request cycle, with `resv_addr` and `resv_master` equal to the request's address and master. Nothing else raises `resv_set`.
- R7: A request with `req_inhibit`=1 changes no memory, raises no reservation, produces no response and moves no counter.
- R8: `rsp_valid` is raised only for a live request with `req_need_rsp`=1.
- R9: Command code 4 (invalidate) changes no memory and answers with `rsp_ok`=1 and `rsp_err`=0.
- R10: Each master has counters with kind codes 0 reads, 1 committed writes, 2 swaps of either kind, 3 bytes read, 4 instruction-fetch bytes read, and 5 bytes written. A swap counts only under kind 2. The counters are zero after reset and saturate at all ones. Kind codes 6 and 7 read as zero.
- R11: `resv_clear` pulses in the request cycle of every request that changes memory, with the request's address on `resv_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 3 | Command code |
| req_master | input | MW | Requesting master |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Size code, 2^code bytes |
| req_wdata | input | 64 | Store data in its byte lanes |
| req_cmp | input | 64 | Compare data in its byte lanes |
| req_linked | input | 1 | Linked read or conditional store |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_inhibit | input | 1 | Suppress the request |
| req_need_rsp | input | 1 | Requester wants a response |
| wr_allow | input | 1 | Monitor lets this write commit |
| resv_set | output | 1 | Register a reservation |
| resv_clear | output | 1 | Memory updated at resv_addr |
| resv_addr | output | AW | Address for the monitor |
| resv_master | output | MW | Master for the monitor |
| rsp_valid | output | 1 | Response present |
| rsp_master | output | MW | Master of the response |
| rsp_data | output | 64 | Old data in its lanes |
| rsp_ok | output | 1 | Operation took effect |
| rsp_err | output | 1 | Request was illegal |
| cnt_master | input | MW | Counter master select |
| cnt_kind | input | 3 | Counter kind select |
| cnt_value | output | CNT_W | Selected counter |

## Verification
The reservation and clear pulses are combinational in the request cycle, so the bench looks at them one time step after it drives a request, before the clock edge. The response fields and the memory and counter updates all take effect on the edge that accepts the request. The bench reads them at the following falling edge, and it reads memory back with later read requests. The counter select port is combinational, so each counter is read one step after its select is driven, in an idle cycle.

// File: rtl/amu_pkg.sv
package amu_pkg;
  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_SWAP  = 3'd2,
    CMD_CSWAP = 3'd3,
    CMD_INVAL = 3'd4
  } amu_cmd_e;

  localparam int NKINDS = 6;

  // number of bytes for a size code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // byte-lane enables for an access of size sz at lane offset off
  function automatic logic [7:0] lane_mask(input logic [1:0] sz, input logic [2:0] off);
    logic [15:0] m;
    m = ((16'd1 << size_bytes(sz)) - 16'd1) << off;
    return m[7:0];
  endfunction

  function automatic logic is_aligned(input logic [1:0] sz, input logic [2:0] off);
    return (off & ((3'd1 << sz) - 3'd1)) == 3'd0;
  endfunction

  function automatic logic [63:0] bit_mask(input logic [7:0] be);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = {8{be[i]}};
    return r;
  endfunction
endpackage

// File: rtl/amu_store.sv
module amu_store #(
  parameter int WORDS = 64,
  localparam int WI = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WI-1:0] idx,
  input  logic          we,
  input  logic [63:0]   wmask,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata
);
  logic [63:0] mem_q [WORDS];

  assign rdata = mem_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else if (we) begin
      mem_q[idx] <= (mem_q[idx] & ~wmask) | (wdata & wmask);
    end
  end
endmodule

// File: rtl/amu_decode.sv
module amu_decode
  import amu_pkg::*;
(
  input  logic        live,
  input  logic [2:0]  cmd,
  input  logic [1:0]  sz,
  input  logic [2:0]  off,
  input  logic        linked,
  input  logic        allow,
  input  logic [63:0] old_word,
  input  logic [63:0] cmp,
  output logic        mem_we,
  output logic [63:0] mem_mask,
  output logic        err_n,
  output logic        ok_n,
  output logic [63:0] data_n,
  output logic        reserve,
  output logic        cnt_rd,
  output logic        cnt_wr,
  output logic        cnt_oth
);
  logic is_rd, is_wr, is_sw, is_cs, is_inv, bad_cmd, bad_align, bad_cs;
  logic legal, cs_match;

  assign is_rd  = cmd == CMD_READ;
  assign is_wr  = cmd == CMD_WRITE;
  assign is_sw  = cmd == CMD_SWAP;
  assign is_cs  = cmd == CMD_CSWAP;
  assign is_inv = cmd == CMD_INVAL;

  assign mem_mask  = bit_mask(lane_mask(sz, off));
  assign bad_cmd   = cmd > CMD_INVAL;
  assign bad_align = !is_aligned(sz, off);
  assign bad_cs    = is_cs && (sz < 2'd2);

  assign err_n = live && (bad_cmd || bad_align || bad_cs);
  assign legal = live && !err_n;

  assign cs_match = ((old_word ^ cmp) & mem_mask) == 64'd0;

  assign mem_we  = legal && ((is_wr && allow) || is_sw || (is_cs && cs_match));
  assign ok_n    = legal && (is_rd || is_inv || is_sw || (is_wr && allow) || (is_cs && cs_match));
  assign data_n  = (legal && (is_rd || is_sw || is_cs)) ? (old_word & mem_mask) : 64'd0;
  assign reserve = legal && is_rd && linked;

  assign cnt_rd  = legal && is_rd;
  assign cnt_wr  = legal && is_wr && allow;
  assign cnt_oth = legal && (is_sw || is_cs);
endmodule

// File: rtl/amu_counters.sv
module amu_counters
  import amu_pkg::*;
#(
  parameter int MASTERS = 4,
  parameter int CNT_W   = 32,
  localparam int MW = (MASTERS > 1) ? $clog2(MASTERS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MW-1:0]    src,
  input  logic             inc_rd,
  input  logic             inc_wr,
  input  logic             inc_oth,
  input  logic             ifetch,
  input  logic [3:0]       nbytes,
  input  logic [MW-1:0]    sel_master,
  input  logic [2:0]       sel_kind,
  output logic [CNT_W-1:0] value
);
  logic [CNT_W-1:0] cnt_q [MASTERS][NKINDS];

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [3:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  logic [3:0] amt [NKINDS];
  always_comb begin
    amt[0] = inc_rd  ? 4'd1 : 4'd0;
    amt[1] = inc_wr  ? 4'd1 : 4'd0;
    amt[2] = inc_oth ? 4'd1 : 4'd0;
    amt[3] = inc_rd  ? nbytes : 4'd0;
    amt[4] = (inc_rd && ifetch) ? nbytes : 4'd0;
    amt[5] = inc_wr  ? nbytes : 4'd0;
  end

  for (genvar m = 0; m < MASTERS; m++) begin : g_master
    for (genvar k = 0; k < NKINDS; k++) begin : g_kind
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q[m][k] <= '0;
        else if (src == MW'(m) && amt[k] != 4'd0) cnt_q[m][k] <= sat_add(cnt_q[m][k], amt[k]);
      end
    end
  end

  always_comb begin
    value = '0;
    for (int m = 0; m < MASTERS; m++)
      for (int k = 0; k < NKINDS; k++)
        if (sel_master == MW'(m) && sel_kind == 3'(k)) value = cnt_q[m][k];
  end
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int MASTERS = 4,
  parameter int WORDS   = 64,
  parameter int CNT_W   = 32,
  localparam int MW = (MASTERS > 1) ? $clog2(MASTERS) : 1,
  localparam int WI = $clog2(WORDS),
  localparam int AW = WI + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  input  logic [MW-1:0]    req_master,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic [63:0]      req_wdata,
  input  logic [63:0]      req_cmp,
  input  logic             req_linked,
  input  logic             req_ifetch,
  input  logic             req_inhibit,
  input  logic             req_need_rsp,
  input  logic             wr_allow,
  output logic             resv_set,
  output logic             resv_clear,
  output logic [AW-1:0]    resv_addr,
  output logic [MW-1:0]    resv_master,
  output logic             rsp_valid,
  output logic [MW-1:0]    rsp_master,
  output logic [63:0]      rsp_data,
  output logic             rsp_ok,
  output logic             rsp_err,
  input  logic [MW-1:0]    cnt_master,
  input  logic [2:0]       cnt_kind,
  output logic [CNT_W-1:0] cnt_value
);
  logic        live;
  logic [63:0] old_word, mem_mask;
  logic        mem_we, err_n, ok_n, reserve;
  logic [63:0] data_n;
  logic        cnt_rd, cnt_wr, cnt_oth;

  assign live = req_valid && !req_inhibit;

  amu_store #(.WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(req_addr[AW-1:3]), .we(mem_we),
    .wmask(mem_mask), .wdata(req_wdata), .rdata(old_word)
  );

  amu_decode u_decode (
    .live(live), .cmd(req_cmd), .sz(req_size), .off(req_addr[2:0]),
    .linked(req_linked), .allow(wr_allow), .old_word(old_word), .cmp(req_cmp),
    .mem_we(mem_we), .mem_mask(mem_mask), .err_n(err_n), .ok_n(ok_n),
    .data_n(data_n), .reserve(reserve), .cnt_rd(cnt_rd), .cnt_wr(cnt_wr),
    .cnt_oth(cnt_oth)
  );

  amu_counters #(.MASTERS(MASTERS), .CNT_W(CNT_W)) u_counters (
    .clk(clk), .rst_n(rst_n), .src(req_master), .inc_rd(cnt_rd),
    .inc_wr(cnt_wr), .inc_oth(cnt_oth), .ifetch(req_ifetch),
    .nbytes(size_bytes(req_size)), .sel_master(cnt_master),
    .sel_kind(cnt_kind), .value(cnt_value)
  );

  assign resv_set    = reserve;
  assign resv_clear  = mem_we;
  assign resv_addr   = req_addr;
  assign resv_master = req_master;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_master <= '0;
      rsp_data   <= '0;
      rsp_ok     <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid <= live && req_need_rsp;
      if (live && req_need_rsp) begin
        rsp_master <= req_master;
        rsp_data   <= data_n;
        rsp_ok     <= ok_n;
        rsp_err    <= err_n;
      end
    end
  end
endmodule

// File: rtl/amu_checker.sv
module amu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_cmd,
  input logic [1:0] req_size,
  input logic       req_linked,
  input logic       req_inhibit,
  input logic       req_need_rsp,
  input logic       wr_allow,
  input logic       mem_we,
  input logic       resv_set,
  input logic       rsp_valid,
  input logic       rsp_err
);
  assert_rsp_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_need_rsp && !req_inhibit));

  assert_inhibit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inhibit) |-> (!mem_we && !resv_set));

  assert_reject_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'd1 && !wr_allow) |-> !mem_we);

  assert_cswap_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_inhibit && req_need_rsp && req_cmd == 3'd3 && req_size < 2'd2)
      |=> (rsp_valid && rsp_err));

  assert_resv_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resv_set |-> (req_valid && req_cmd == 3'd0 && req_linked));

  assert_inval_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'd4) |-> !mem_we);
endmodule

bind atomic_mem_unit amu_checker u_amu_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_size(req_size), .req_linked(req_linked), .req_inhibit(req_inhibit),
  .req_need_rsp(req_need_rsp), .wr_allow(wr_allow), .mem_we(mem_we),
  .resv_set(resv_set), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/atomic_mem_unit_bench.sv
module atomic_mem_unit_bench;
  localparam int MASTERS = 2;
  localparam int WORDS   = 4;
  localparam int CNT_W   = 8;
  localparam int NBYTES  = WORDS * 8;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_linked = 0, req_ifetch = 0, req_inhibit = 0;
  logic        req_need_rsp = 0, wr_allow = 0;
  logic [2:0]  req_cmd = 0;
  logic [0:0]  req_master = 0;
  logic [4:0]  req_addr = 0;
  logic [1:0]  req_size = 0;
  logic [63:0] req_wdata = 0, req_cmp = 0;
  logic        resv_set, resv_clear, rsp_valid, rsp_ok, rsp_err;
  logic [4:0]  resv_addr;
  logic [0:0]  resv_master, rsp_master;
  logic [63:0] rsp_data;
  logic [0:0]  cnt_master = 0;
  logic [2:0]  cnt_kind = 0;
  logic [7:0]  cnt_value;

  atomic_mem_unit #(.MASTERS(MASTERS), .WORDS(WORDS), .CNT_W(CNT_W)) u_atomic_mem_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_master(req_master), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_cmp(req_cmp), .req_linked(req_linked),
    .req_ifetch(req_ifetch), .req_inhibit(req_inhibit), .req_need_rsp(req_need_rsp),
    .wr_allow(wr_allow), .resv_set(resv_set), .resv_clear(resv_clear),
    .resv_addr(resv_addr), .resv_master(resv_master), .rsp_valid(rsp_valid),
    .rsp_master(rsp_master), .rsp_data(rsp_data), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .cnt_master(cnt_master), .cnt_kind(cnt_kind), .cnt_value(cnt_value)
  );

  int checks = 0, failures = 0;
  logic [7:0] bmem [NBYTES];
  int exp_cnt [MASTERS][6];

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void bump(input int m, input int k, input int v);
    exp_cnt[m][k] = (exp_cnt[m][k] + v > CMAX) ? CMAX : exp_cnt[m][k] + v;
  endfunction

  function automatic logic [63:0] pattern(input int a, input int salt);
    return 64'h0f1e2d3c4b5a6978 ^ (64'(a + 1) * 64'h9e3779b97f4a7c15) ^ 64'(salt * 7919);
  endfunction

  // build the expected result from the requirements, update the model, then check
  task automatic issue(input string tag, input int cmd, input int m, input int addr,
                       input int sz, input logic [63:0] wd, input logic [63:0] cmp,
                       input bit linked, input bit ifetch, input bit inhibit,
                       input bit need, input bit allow);
    int nb, off;
    bit aligned, err, ok, match, writes, eok;
    logic [63:0] old;
    nb = 1 << sz;
    off = addr % 8;
    aligned = (addr % nb) == 0;
    err = !inhibit && (cmd > 4 || !aligned || (cmd == 3 && sz < 2));
    ok = !inhibit && !err;
    old = 0;
    match = 1;
    if (ok) begin
      for (int i = 0; i < nb; i++) begin
        old[(off+i)*8 +: 8] = bmem[addr+i];
        if (cmp[(off+i)*8 +: 8] != bmem[addr+i]) match = 0;
      end
    end
    writes = ok && ((cmd == 1 && allow) || cmd == 2 || (cmd == 3 && match));
    eok = ok && (cmd == 0 || cmd == 4 || cmd == 2 || (cmd == 1 && allow) || (cmd == 3 && match));

    @(negedge clk);
    req_valid = 1; req_cmd = 3'(cmd); req_master = 1'(m); req_addr = 5'(addr);
    req_size = 2'(sz); req_wdata = wd; req_cmp = cmp; req_linked = linked;
    req_ifetch = ifetch; req_inhibit = inhibit; req_need_rsp = need; wr_allow = allow;
    #1;
    chk(resv_set == (ok && cmd == 0 && linked), tag, "resv_set", 64'(resv_set), 64'(ok && cmd == 0 && linked));
    chk(resv_clear == writes, tag, "resv_clear", 64'(resv_clear), 64'(writes));
    if (resv_set || resv_clear)
      chk(resv_addr == 5'(addr) && resv_master == 1'(m), tag, "resv_addr", 64'(resv_addr), 64'(addr));
    @(posedge clk);
    #1;
    req_valid = 0;
    if (writes) for (int i = 0; i < nb; i++) bmem[addr+i] = wd[(off+i)*8 +: 8];
    if (ok && cmd == 0) begin
      bump(m, 0, 1); bump(m, 3, nb);
      if (ifetch) bump(m, 4, nb);
    end
    if (ok && cmd == 1 && allow) begin bump(m, 1, 1); bump(m, 5, nb); end
    if (ok && (cmd == 2 || cmd == 3)) bump(m, 2, 1);
    @(negedge clk);
    chk(rsp_valid == (!inhibit && need), tag, "rsp_valid", 64'(rsp_valid), 64'(!inhibit && need));
    if (!inhibit && need) begin
      chk(rsp_err == err, tag, "rsp_err", 64'(rsp_err), 64'(err));
      chk(rsp_ok == eok, tag, "rsp_ok", 64'(rsp_ok), 64'(eok));
      chk(rsp_data == ((ok && cmd != 1 && cmd != 4) ? old : 64'd0), tag, "rsp_data", rsp_data,
          (ok && cmd != 1 && cmd != 4) ? old : 64'd0);
      chk(rsp_master == 1'(m), tag, "rsp_master", 64'(rsp_master), 64'(m));
    end
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < NBYTES; a += 8)
      issue(tag, 0, 0, a, 3, 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic check_counters;
    for (int m = 0; m < MASTERS; m++)
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        cnt_master = 1'(m); cnt_kind = 3'(k);
        #1;
        // R10: kinds 0..5 per master, 6 and 7 read zero
        chk(int'(cnt_value) == ((k < 6) ? exp_cnt[m][k] : 0), "R10", "cnt_value",
            64'(cnt_value), 64'((k < 6) ? exp_cnt[m][k] : 0));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBYTES; i++) bmem[i] = 0;
    for (int m = 0; m < MASTERS; m++) for (int k = 0; k < 6; k++) exp_cnt[m][k] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(rsp_valid == 0 && resv_set == 0 && resv_clear == 0, "R8", "reset outputs", 64'(rsp_valid), 0);
    rst_n = 1;
    check_counters();

    // R2: byte writes across every address, alternating masters
    for (int a = 0; a < NBYTES; a++)
      issue("R2", 1, a % 2, a, 0, pattern(a, 1), 0, 0, 0, 0, 1, 1);
    // R1: reads of every aligned size at every aligned address, R6 linked on size 3
    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < NBYTES; a += (1 << sz))
        issue(sz == 3 ? "R6" : "R1", 0, (a / 8) % 2, a, sz, 0, 0, sz == 3, a[3], 0, 1, 0);
    // R2: wider writes with monitor rejecting every third one
    for (int sz = 1; sz < 4; sz++)
      for (int a = 0; a < NBYTES; a += (1 << sz))
        issue("R2", 1, a % 2, a, sz, pattern(a, sz + 5), 0, 1, 0, 0, 1, (a % 3) != 0);
    read_all("R2");
    // R3: swaps of every size, R11 clear pulse checked inside
    for (int sz = 0; sz < 4; sz++)
      for (int a = 0; a < NBYTES; a += 8 + (1 << sz))
        issue("R3", 2, 1, a - (a % (1 << sz)), sz, pattern(a, 40 + sz), 0, 0, 0, 0, 1, 0);
    read_all("R11");
    // R4: compare swaps, one matching and one not, sizes 4 and 8
    for (int sz = 2; sz < 4; sz++)
      for (int a = 0; a < NBYTES; a += 8) begin
        logic [63:0] cur;
        cur = 0;
        for (int i = 0; i < 8; i++) cur[i*8 +: 8] = bmem[a+i];
        issue("R4", 3, 0, a, sz, pattern(a, 60 + sz), cur ^ 64'h0100_0000_0000_0001, 0, 0, 0, 1, 0);
        issue("R4", 3, 0, a, sz, pattern(a, 70 + sz), cur, 0, 0, 0, 1, 0);
      end
    read_all("R4");
    // R5: illegal compare sizes, misalignment, unsupported commands
    issue("R5", 3, 1, 4, 0, 64'hff, 0, 0, 0, 0, 1, 0);
    issue("R5", 3, 1, 6, 1, 64'hffff, 0, 0, 0, 0, 1, 0);
    issue("R5", 1, 1, 3, 1, '1, 0, 0, 0, 0, 1, 1);
    issue("R5", 2, 1, 12, 3, '1, 0, 0, 0, 0, 1, 0);
    for (int c = 5; c < 8; c++) issue("R5", c, 0, 8, 3, '1, 0, 0, 0, 0, 1, 1);
    // R7: inhibited write, swap and linked read
    issue("R7", 1, 0, 16, 3, '1, 0, 0, 0, 1, 1, 1);
    issue("R7", 2, 1, 8, 2, '1, 0, 0, 0, 1, 1, 0);
    issue("R7", 0, 1, 0, 3, 0, 0, 1, 1, 1, 1, 0);
    // R8: no response requested, memory still updated
    issue("R8", 1, 0, 24, 3, 64'h1122334455667788, 0, 0, 0, 0, 0, 1);
    issue("R8", 0, 1, 24, 3, 0, 0, 0, 0, 0, 0, 0);
    // R9: invalidate
    issue("R9", 4, 0, 24, 3, '1, 0, 0, 0, 0, 1, 1);
    read_all("R9");
    check_counters();
    // R10: saturation of byte counts on master 1
    for (int n = 0; n < 40; n++) issue("R10", 0, 1, (n % 4) * 8, 3, 0, 0, 0, 1, 0, 1, 0);
    check_counters();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule